// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on a single output line. An 8-bit mode register selects the frame format: transmit enable, parity mode, character length and stop-bit count. A byte is handed over on a valid/ready interface. The block then drives a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits.

Bit timing comes from a one-cycle baud tick that an external rate generator supplies. Each bit lasts a fixed number of ticks, and clock cycles without a tick do not advance the frame. When transmission is disabled, the line rests high and a port-mode flag tells the pin multiplexer to give the pin to general-purpose use. The whole frame is built when the byte is accepted, so a mode write made mid-frame only affects later frames. A one-cycle completion pulse marks the end of every frame.

Top module: `sertx_top`

## Requirements
- R1: After reset the mode register holds 0x00. The line is high, port_mode is 1, and in_ready, busy and done are all 0.
- R2: Mode bit 7 is transmit enable. port_mode equals the inverse of bit 7. in_ready is 1 only when bit 7 is 1 and no frame is in flight. The line is high whenever no frame is in flight.
- R3: A frame begins in the cycle after the valid/ready handshake with a low start bit, followed by data bits LSB first. Every bit lasts TICKS_PER_BIT baud ticks, and cycles without a tick do not advance the frame.
- R4: Mode bit 3 selects the character length. A 0 sends DATA_W-1 data bits (the top data bit is not sent). A 1 sends DATA_W data bits.
- R5: Mode bits 5:4 select parity, sent after the data bits. 00 sends no parity bit. 01 always sends 0. 10 sends odd parity. 11 sends even parity. Parity covers only the data bits that are sent.
- R6: Mode bit 2 selects the stop length. A 0 sends one high stop bit and a 1 sends two. After the last stop bit the line stays high.
- R7: busy rises in the cycle after the handshake and falls when the final stop bit ends. While busy is 1, in_ready is 0.
- R8: done is a one-cycle pulse in the first cycle after the final stop bit ends. It coincides with busy falling.
- R9: The format is fixed at the handshake. A mode write during a frame, including one that clears transmit enable, does not change that frame. The write does take effect on port_mode and in_ready.
- R10: Mode bits 6, 1 and 0 have no effect on the transmitted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_data | input | 8 | Mode register write value |
| baud_tick | input | 1 | One-cycle timing tick from the rate generator |
| in_valid | input | 1 | Byte offered for transmission |
| in_data | input | DATA_W | Byte to send |
| in_ready | output | 1 | Block can accept a byte |
| tx_line | output | 1 | Serial output line, high at rest |
| port_mode | output | 1 | Pin is in general-port use (transmit disabled) |
| busy | output | 1 | Frame in flight |
| done | output | 1 | One-cycle pulse at frame end |

## Verification
The bench builds the block with TICKS_PER_BIT = 4 and the default DATA_W = 8. This keeps every frame short enough to cover all four parity modes, both character lengths and both stop lengths in a few thousand cycles. The bench also throttles the tick to one in three cycles. This confirms that frame progress follows ticks rather than clock cycles. It also places a mode write in the middle of a frame, which checks that the format is captured at the handshake.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } par_mode_e;

  typedef struct packed {
    logic      enable;
    par_mode_e par;
    logic      len_full;
    logic      stop_two;
  } tx_cfg_t;

  // Bit positions of the mode byte: 7 enable, 5:4 parity, 3 length, 2 stop.
  function automatic tx_cfg_t decode_mode(input logic [7:0] m);
    tx_cfg_t c;
    c.enable   = m[7];
    c.par      = par_mode_e'(m[5:4]);
    c.len_full = m[3];
    c.stop_two = m[2];
    return c;
  endfunction

endpackage

// File: rtl/sertx_mode_reg.sv
module sertx_mode_reg
  import sertx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output tx_cfg_t    cfg
);

  logic unused_mode_bits;
  assign unused_mode_bits = ^{wdata[6], wdata[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) cfg <= decode_mode(8'h00);
    else if (we) cfg <= decode_mode(wdata);
  end

endmodule

// File: rtl/sertx_bit_timer.sv
module sertx_bit_timer #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic tick,
  output logic bit_end
);

  localparam int CW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_BIT - 1);

  logic [CW-1:0] cnt;

  assign bit_end = run && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !run) cnt <= '0;
    else if (bit_end) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && !restart) |=> $stable(cnt)); // R3

endmodule

// File: rtl/sertx_frame_shifter.sv
module sertx_frame_shifter
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  tx_cfg_t           cfg,
  input  logic              advance,
  output logic              line,
  output logic              last
);

  localparam int FRAME_MAX = 1 + DATA_W + 1 + 2;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  logic [FRAME_MAX-1:0] frame;
  logic [CNT_W-1:0]     bits_left;

  function automatic int char_len(input logic full);
    return full ? DATA_W : DATA_W - 1;
  endfunction

  function automatic logic parity_bit(input logic [DATA_W-1:0] d, input tx_cfg_t c);
    logic ones;
    int   n;
    ones = 1'b0;
    n    = char_len(c.len_full);
    for (int i = 0; i < DATA_W; i++) if (i < n) ones = ones ^ d[i];
    case (c.par)
      PAR_ODD:  return ~ones;
      PAR_EVEN: return ones;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic [FRAME_MAX-1:0] build_frame(input logic [DATA_W-1:0] d,
                                                       input tx_cfg_t c);
    logic [FRAME_MAX-1:0] v;
    int n;
    v    = '1;
    v[0] = 1'b0;
    n    = char_len(c.len_full);
    for (int i = 0; i < DATA_W; i++) if (i < n) v[i+1] = d[i];
    for (int i = 0; i < FRAME_MAX; i++)
      if (c.par != PAR_NONE && i == n + 1) v[i] = parity_bit(d, c);
    return v;
  endfunction

  function automatic logic [CNT_W-1:0] frame_bits(input tx_cfg_t c);
    int n;
    n = 1 + char_len(c.len_full) + ((c.par != PAR_NONE) ? 1 : 0) + (c.stop_two ? 2 : 1);
    return CNT_W'(n);
  endfunction

  assign line = frame[0];
  assign last = (bits_left == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame     <= '1;
      bits_left <= '0;
    end else if (load) begin
      frame     <= build_frame(data, cfg);
      bits_left <= frame_bits(cfg);
    end else if (advance) begin
      frame     <= {1'b1, frame[FRAME_MAX-1:1]};
      bits_left <= bits_left - 1'b1;
    end
  end

  AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !line); // R3
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && last) |=> line); // R6

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_data,
  input  logic              baud_tick,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              tx_line,
  output logic              port_mode,
  output logic              busy,
  output logic              done
);

  tx_cfg_t cfg;
  logic    accept;
  logic    bit_end;
  logic    last_bit;
  logic    frame_end;

  sertx_mode_reg u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_data),
    .cfg   (cfg)
  );

  assign port_mode = ~cfg.enable;
  assign in_ready  = cfg.enable && !busy;
  assign accept    = in_valid && in_ready;
  assign frame_end = bit_end && last_bit;

  sertx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .restart (accept),
    .tick    (baud_tick),
    .bit_end (bit_end)
  );

  sertx_frame_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .data    (in_data),
    .cfg     (cfg),
    .advance (bit_end),
    .line    (tx_line),
    .last    (last_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= frame_end;
      if (accept) busy <= 1'b1;
      else if (frame_end) busy <= 1'b0;
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy); // R7
  AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_line); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R8

endmodule

// File: tb/sertx_top_test.sv
module sertx_top_test;

  localparam int TPB = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_data = 8'h00;
  logic       baud_tick = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, tx_line, port_mode, busy, done;

  int tests = 0;
  int fails = 0;
  int tick_div = 1;
  logic [7:0] cur_mode = 8'h00;

  typedef struct {
    logic [15:0] bits;
    int          nb;
    string       req;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  sertx_top #(.DATA_W(8), .TICKS_PER_BIT(TPB)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .baud_tick(baud_tick), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .tx_line(tx_line), .port_mode(port_mode),
    .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected frame built from the requirement text.
  function automatic exp_t make_exp(input logic [7:0] md, input logic [7:0] d,
                                    input string req);
    exp_t e;
    int len, n, ones;
    len = md[3] ? 8 : 7;
    e.bits = '1;
    e.bits[0] = 1'b0;
    ones = 0;
    for (int i = 0; i < len; i++) begin
      e.bits[i+1] = d[i];
      ones += d[i];
    end
    n = len + 1;
    case (md[5:4])
      2'b01: begin e.bits[n] = 1'b0; n++; end
      2'b10: begin e.bits[n] = (ones % 2 == 0); n++; end
      2'b11: begin e.bits[n] = (ones % 2 == 1); n++; end
      default: ;
    endcase
    n += md[2] ? 2 : 1;
    e.nb = n;
    e.req = req;
    return e;
  endfunction

  // Tick generator.
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      baud_tick = (c % tick_div) == 0;
      c++;
    end
  end

  // Monitor: decodes the line by counting ticks after each handshake.
  bit   act = 0;
  bit   prev_ready = 0;
  int   m = 0;
  int   ferr = 0;
  exp_t cur;
  always begin
    @(posedge clk);
    #1;
    if (!rst_n) begin
      act = 0;
      prev_ready = 0;
    end else begin
      if (act) begin
        if (baud_tick) m++;
        if (m / TPB < cur.nb) begin
          if (tx_line !== cur.bits[m / TPB] || busy !== 1'b1 || done !== 1'b0 || in_ready !== 1'b0)
            ferr++;
        end else begin
          check(done === 1'b1 && busy === 1'b0 && tx_line === 1'b1, "R8",
                "done/busy at frame end", int'(done), 1);
          check(ferr == 0, cur.req, "frame bit mismatches", ferr, 0);
          act = 0;
        end
      end else if (done === 1'b1) begin
        check(0, "R8", "stray done", 1, 0);
      end
      if (!act && prev_ready && in_valid) begin
        if (q.size() == 0) check(0, "R7", "unexpected accept", 1, 0);
        else begin
          cur = q.pop_front();
          act = 1;
          m = 0;
          ferr = (tx_line !== 1'b0 || busy !== 1'b1) ? 1 : 0;
        end
      end
      prev_ready = in_ready;
    end
  end

  task automatic write_mode(input logic [7:0] md);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_data = md;
    @(negedge clk);
    cfg_we = 1'b0;
    cur_mode = md;
  endtask

  task automatic send(input logic [7:0] d, input string req);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    q.push_back(make_exp(cur_mode, d, req));
    in_valid = 1'b1;
    in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy || act || q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] md, input logic [7:0] d, input string req);
    write_mode(md);
    send(d, req);
    wait_idle();
  endtask

  bit wd_hit = 0;
  initial begin
    #1000000;
    wd_hit = 1;
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check(tx_line === 1'b1, "R1", "line in reset", int'(tx_line), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_line === 1'b1, "R1", "line after reset", int'(tx_line), 1);
        check(port_mode === 1'b1, "R1", "port_mode after reset", int'(port_mode), 1);
        check(in_ready === 1'b0, "R1", "ready after reset", int'(in_ready), 0);
        check(busy === 1'b0 && done === 1'b0, "R1", "busy/done after reset", int'(busy), 0);

        // R2: offer data while disabled, nothing happens
        in_valid = 1'b1;
        in_data = 8'h00;
        repeat (10) @(negedge clk);
        in_valid = 1'b0;
        check(busy === 1'b0, "R2", "busy while disabled", int'(busy), 0);
        check(tx_line === 1'b1, "R2", "line while disabled", int'(tx_line), 1);

        write_mode(8'h88);
        check(port_mode === 1'b0, "R2", "port_mode when enabled", int'(port_mode), 0);
        check(in_ready === 1'b1, "R2", "ready when enabled", int'(in_ready), 1);

        frame(8'h88, 8'h3C, "R3");
        frame(8'h88, 8'hA5, "R3");
        frame(8'h80, 8'hD5, "R4");
        frame(8'h80, 8'hFF, "R4");
        frame(8'h88, 8'h00, "R5");
        frame(8'h98, 8'hFF, "R5");
        frame(8'hA8, 8'h13, "R5");
        frame(8'hB8, 8'h13, "R5");
        frame(8'hA0, 8'h81, "R5");
        frame(8'hB4, 8'hC3, "R6");
        frame(8'h8C, 8'h5A, "R6");
        frame(8'hCB, 8'h69, "R10");

        // R3: throttled ticks
        tick_div = 3;
        frame(8'hA8, 8'h6E, "R3");
        tick_div = 1;

        // R7: back-to-back frames
        write_mode(8'h9C);
        send(8'h11, "R7");
        send(8'hEE, "R7");
        wait_idle();

        // R9: mode rewritten mid-frame, including disable
        write_mode(8'h88);
        send(8'h3C, "R9");
        repeat (6) @(negedge clk);
        cfg_we = 1'b1;
        cfg_data = 8'h34;
        @(negedge clk);
        cfg_we = 1'b0;
        cur_mode = 8'h34;
        check(port_mode === 1'b1, "R9", "port_mode after mid-frame disable", int'(port_mode), 1);
        check(busy === 1'b1, "R9", "frame continues", int'(busy), 1);
        wait_idle();
        check(in_ready === 1'b0, "R9", "ready after disabled frame", int'(in_ready), 0);
        check(tx_line === 1'b1, "R2", "line idle when disabled", int'(tx_line), 1);
        repeat (5) @(negedge clk);
      end
      begin
        wait (wd_hit);
        check(0, "R7", "watchdog expired", 0, 1);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule